// File: doc/BRIEF.md
# Streaming Recursive DFT Cell Chain

This block computes an N-point discrete Fourier transform (N = 3 by default) over a continuous stream of real 16-bit samples. It is a one-dimensional chain of N identical cells. Cell k owns frequency bin k and builds it with a first-order recursion: each time a sample arrives, the cell adds it to its complex accumulator and rotates the sum by a constant twiddle factor held in a small per-cell coefficient table. Samples enter cell 0 straight from the input and move one cell further on each step, so cell k works on the same frame k steps later than cell 0.

A frame is marked by raising `in_start` with its first sample. Frames may follow each other with no gap. The bins of a frame leave the block in order 0, 1, ..., N-1 on consecutive steps, and the steady-state rate is one complete transform every N steps with no stall. A step is any clock cycle with `in_valid` high. A cycle with `in_valid` low freezes the whole chain, so a frame only drains out when N-1 further steps follow its last sample.

Each cell is a two-state machine. In `CELL_IDLE` it ignores samples. The transition *arm* (a step carrying a start marker) moves it to `CELL_RUN`. In `CELL_RUN`, *accumulate* (a step without a marker) keeps it running. *Restart* (a step with a marker) reloads the accumulator with the new frame. *Finish* (the N-th sample of the frame) returns it to `CELL_IDLE` and presents the bin to the output selector.

Top module: `sys_dft_chain`

## Requirements
- R1: For a frame x(0..N-1), the result for bin k is X(k) = sum over n of x(n)·e^(−j2πkn/N), scaled by 2^−G with G = ceil(log2 N) (a factor of 1/4 for N = 3). Each result is rounded to signed 16-bit real and imaginary parts and lies within 2 LSB of the exact value.
- R2: Results leave in frame order, and within each frame in bin order 0..N-1. `out_bin` carries the bin number as an unsigned integer. Frames sent back to back with no idle steps give one result on every step, with no gap between the first and the last result.
- R3: Counting from the step that carries a frame's last sample, bin k is presented with `out_valid` high in the cycle that follows k further steps.
- R4: A cycle with `in_valid` low changes no accumulator, cell state or pipeline stage, and `out_valid` is low in the cycle after it. The results of a frame with idle cycles inside it equal those of the same frame sent without gaps.
- R5: A start marker arriving while a frame is part-way through discards the partial sums, and the new frame is computed from its own samples only. The abandoned frame produces no result.
- R6: Samples that arrive without a start marker while the cells are idle produce no result.
- R7: An active-low reset clears every accumulator, cell state and pipeline stage. After reset `out_valid` is low, and a frame cut short by the reset yields nothing.
- R8: At most one cell finishes on any step, and each result is presented with `out_valid` high for exactly one cycle.
- R9: `in_start` and `in_sample` are ignored in cycles where `in_valid` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Step enable; low freezes the chain |
| in_start | input | 1 | Marks the first sample of a frame |
| in_sample | input | 16 | Real input sample, signed two's complement |
| out_valid | output | 1 | One-cycle pulse: a bin result is present |
| out_bin | output | $clog2(N) | Index of the bin being presented |
| out_re | output | 16 | Real part of the result, signed, scaled by 2^−G |
| out_im | output | 16 | Imaginary part of the result, signed, scaled by 2^−G |

## Verification
Bin 0 of a frame is due in the cycle right after the step that consumes the frame's last sample. Bin k follows k steps later, and the bench checks this slot directly by sampling `out_valid` and `out_bin` on the falling edge after each step. All other results go through an in-order expectation queue filled when a frame is sent, so ordering, lost results and extra results are caught no matter when they arrive. Each idle cycle is checked at the falling edge after its rising edge, where `out_valid` must already be low. Expected bins are computed in the bench with real-number sine and cosine sums.

// File: rtl/gz_pkg.sv
package gz_pkg;

    typedef enum logic {
        CELL_IDLE = 1'b0,
        CELL_RUN  = 1'b1
    } cell_state_e;

    // Round a real value to a signed fixed-point integer with 'frac' fraction bits.
    function automatic int to_fixed(real v, int frac);
        real s;
        s = v * real'(1 << frac);
        return (s >= 0.0) ? $rtoi(s + 0.5) : -$rtoi(0.5 - s);
    endfunction

endpackage

// File: rtl/gz_coef_rom.sv
// Constant twiddle table of one cell: rotation e^(+j2*pi*K/N) in fixed point.
module gz_coef_rom #(
    parameter int N    = 3,
    parameter int K    = 0,
    parameter int CWID = 16,
    parameter int CF   = 14
) (
    output logic signed [CWID-1:0] c_re,
    output logic signed [CWID-1:0] c_im
);
    localparam real ANG  = 6.283185307179586 * real'(K) / real'(N);
    localparam int  RE_I = gz_pkg::to_fixed($cos(ANG), CF);
    localparam int  IM_I = gz_pkg::to_fixed($sin(ANG), CF);

    assign c_re = CWID'(RE_I);
    assign c_im = CWID'(IM_I);
endmodule

// File: rtl/gz_cell.sv
// One bin cell: acc <- (acc + x) * W^-K, reloaded on a start marker.
module gz_cell
    import gz_pkg::*;
#(
    parameter int N    = 3,
    parameter int K    = 0,
    parameter int DW   = 16,
    parameter int AW   = 23,
    parameter int CWID = 16,
    parameter int CF   = 14,
    parameter int FB   = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 step,
    input  logic                 lnk_start,
    input  logic signed [DW-1:0] lnk_x,
    output logic                 fin,
    output logic signed [AW-1:0] nxt_re,
    output logic signed [AW-1:0] nxt_im
);
    localparam int CNTW = $clog2(N + 1);
    localparam int PW   = AW + CWID + 1;

    cell_state_e          st_q, st_d;
    logic [CNTW-1:0]      cnt_q, cnt_d;
    logic signed [AW-1:0] acc_re_q, acc_im_q;
    logic signed [AW-1:0] xs, sum_re, sum_im;
    logic signed [CWID-1:0] c_re, c_im;
    logic signed [PW-1:0] p_re, p_im, sh_re, sh_im;
    logic                 cont, load;
    logic                 unused_hi;

    gz_coef_rom #(.N(N), .K(K), .CWID(CWID), .CF(CF)) u_rom (
        .c_re (c_re),
        .c_im (c_im)
    );

    assign cont = (st_q == CELL_RUN) && !lnk_start;
    assign load = step && (lnk_start || (st_q == CELL_RUN));
    assign xs   = {{(AW-DW-FB){lnk_x[DW-1]}}, lnk_x, {FB{1'b0}}};

    // Pre-add then complex rotate, rounding back to the accumulator grid.
    always_comb begin
        sum_re = cont ? acc_re_q + xs : xs;
        sum_im = cont ? acc_im_q : '0;
        p_re   = PW'(sum_re) * PW'(c_re) - PW'(sum_im) * PW'(c_im);
        p_im   = PW'(sum_re) * PW'(c_im) + PW'(sum_im) * PW'(c_re);
        sh_re  = (p_re + PW'(1 <<< (CF - 1))) >>> CF;
        sh_im  = (p_im + PW'(1 <<< (CF - 1))) >>> CF;
    end
    assign nxt_re    = sh_re[AW-1:0];
    assign nxt_im    = sh_im[AW-1:0];
    assign unused_hi = ^{sh_re[PW-1:AW], sh_im[PW-1:AW]};

    assign fin = step && cont && (cnt_q == CNTW'(N - 1));

    // Next-state and counter logic.
    always_comb begin
        st_d  = st_q;
        cnt_d = cnt_q;
        unique case (st_q)
            CELL_IDLE: begin
                if (step && lnk_start) begin
                    st_d  = CELL_RUN;
                    cnt_d = CNTW'(1);
                end
            end
            CELL_RUN: begin
                if (step && lnk_start) begin
                    cnt_d = CNTW'(1);
                end else if (fin) begin
                    st_d  = CELL_IDLE;
                    cnt_d = '0;
                end else if (step) begin
                    cnt_d = cnt_q + CNTW'(1);
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= CELL_IDLE;
            cnt_q <= '0;
        end else begin
            st_q  <= st_d;
            cnt_q <= cnt_d;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_re_q <= '0;
            acc_im_q <= '0;
        end else if (load) begin
            acc_re_q <= nxt_re;
            acc_im_q <= nxt_im;
        end
    end

    // R4
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !step |=> $stable(acc_re_q) && $stable(acc_im_q) && $stable(st_q) && $stable(cnt_q));
    // R6
    idle_stay_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == CELL_IDLE) && !(step && lnk_start) |=> st_q == CELL_IDLE);
    // R2
    cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q == CELL_RUN |-> (cnt_q != '0) && (cnt_q < CNTW'(N)));
endmodule

// File: rtl/gz_out_sel.sv
// Picks the one finishing cell, scales and rounds it, registers the result.
module gz_out_sel #(
    parameter int N  = 3,
    parameter int DW = 16,
    parameter int AW = 23,
    parameter int S  = 6,
    parameter int BW = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 step,
    input  logic [N-1:0]         fin,
    input  logic signed [AW-1:0] res_re [N],
    input  logic signed [AW-1:0] res_im [N],
    output logic                 out_valid,
    output logic [BW-1:0]        out_bin,
    output logic signed [DW-1:0] out_re,
    output logic signed [DW-1:0] out_im
);
    logic [BW-1:0]        pick_bin;
    logic signed [AW-1:0] pick_re, pick_im, sc_re, sc_im;
    logic                 unused_hi;

    always_comb begin
        pick_bin = '0;
        pick_re  = '0;
        pick_im  = '0;
        for (int k = 0; k < N; k++) begin
            if (fin[k]) begin
                pick_bin = BW'(k);
                pick_re  = res_re[k];
                pick_im  = res_im[k];
            end
        end
        sc_re = (pick_re + AW'(1 <<< (S - 1))) >>> S;
        sc_im = (pick_im + AW'(1 <<< (S - 1))) >>> S;
    end
    assign unused_hi = ^{sc_re[AW-1:DW], sc_im[AW-1:DW]};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_bin   <= '0;
            out_re    <= '0;
            out_im    <= '0;
        end else begin
            out_valid <= step && (|fin);
            if (step && (|fin)) begin
                out_bin <= pick_bin;
                out_re  <= sc_re[DW-1:0];
                out_im  <= sc_im[DW-1:0];
            end
        end
    end

    // R8
    pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !(step && (|fin)) |=> !out_valid);
endmodule

// File: rtl/sys_dft_chain.sv
module sys_dft_chain #(
    parameter int N    = 3,
    parameter int DW   = 16,
    parameter int CWID = 16,
    parameter int CF   = 14,
    parameter int FB   = 4
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          in_valid,
    input  logic                          in_start,
    input  logic signed [DW-1:0]          in_sample,
    output logic                          out_valid,
    output logic [$clog2(N)-1:0]          out_bin,
    output logic signed [DW-1:0]          out_re,
    output logic signed [DW-1:0]          out_im
);
    localparam int G  = $clog2(N);
    localparam int BW = $clog2(N);
    localparam int AW = DW + 1 + G + FB;
    localparam int S  = G + FB;

    logic signed [DW-1:0] dly_x [N-1];
    logic                 dly_s [N-1];
    logic [N-1:0]         fin;
    logic signed [AW-1:0] res_re [N];
    logic signed [AW-1:0] res_im [N];

    // Sample and marker travel one cell per step.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int j = 0; j < N - 1; j++) begin
                dly_x[j] <= '0;
                dly_s[j] <= 1'b0;
            end
        end else if (in_valid) begin
            dly_x[0] <= in_sample;
            dly_s[0] <= in_start;
            for (int j = 1; j < N - 1; j++) begin
                dly_x[j] <= dly_x[j-1];
                dly_s[j] <= dly_s[j-1];
            end
        end
    end

    for (genvar k = 0; k < N; k++) begin : g_cell
        logic signed [DW-1:0] cx;
        logic                 cs;
        if (k == 0) begin : g_src_in
            assign cx = in_sample;
            assign cs = in_start;
        end else begin : g_src_dly
            assign cx = dly_x[k-1];
            assign cs = dly_s[k-1];
        end
        gz_cell #(.N(N), .K(k), .DW(DW), .AW(AW), .CWID(CWID), .CF(CF), .FB(FB)) u_cell (
            .clk       (clk),
            .rst_n     (rst_n),
            .step      (in_valid),
            .lnk_start (cs),
            .lnk_x     (cx),
            .fin       (fin[k]),
            .nxt_re    (res_re[k]),
            .nxt_im    (res_im[k])
        );
    end

    gz_out_sel #(.N(N), .DW(DW), .AW(AW), .S(S), .BW(BW)) u_out (
        .clk       (clk),
        .rst_n     (rst_n),
        .step      (in_valid),
        .fin       (fin),
        .res_re    (res_re),
        .res_im    (res_im),
        .out_valid (out_valid),
        .out_bin   (out_bin),
        .out_re    (out_re),
        .out_im    (out_im)
    );

    // R8
    one_fin_chk: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(fin));
    // R4
    freeze_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);
    // R3
    bin0_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && fin[0] |=> out_valid && (out_bin == '0));
    // R2
    bin_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> int'(out_bin) < N);
endmodule

// File: tb/test_sys_dft_chain.sv
module test_sys_dft_chain;
    localparam int NP = 3;
    localparam int G  = $clog2(NP);
    localparam int BURST = 40;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 1'b0;
    logic in_start = 1'b0;
    logic signed [15:0] in_sample = '0;
    logic out_valid;
    logic [$clog2(NP)-1:0] out_bin;
    logic signed [15:0] out_re, out_im;

    always #10 clk = ~clk;

    sys_dft_chain #(.N(NP)) i_sys_dft_chain (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_start(in_start),
        .in_sample(in_sample), .out_valid(out_valid), .out_bin(out_bin),
        .out_re(out_re), .out_im(out_im)
    );

    int checks = 0;
    int fails = 0;
    int cyc = 0;
    int outs = 0;
    int first_out = -1;
    int last_out = -1;
    bit done = 1'b0;
    int q_bin[$];
    int q_re[$];
    int q_im[$];
    string q_tag[$];
    int unsigned lfsr = 32'h1234_5678;

    always @(posedge clk) cyc++;

    task automatic chk(input bit ok, input string tag, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", checks - fails, checks);
    endtask

    function automatic int dft_part(input int x[NP], input int k, input bit imag);
        real acc;
        real ang;
        acc = 0.0;
        for (int n = 0; n < NP; n++) begin
            ang = 6.283185307179586 * real'(k * n) / real'(NP);
            acc += imag ? -real'(x[n]) * $sin(ang) : real'(x[n]) * $cos(ang);
        end
        acc = acc / real'(1 << G);
        return (acc >= 0.0) ? $rtoi(acc + 0.5) : -$rtoi(0.5 - acc);
    endfunction

    function automatic int next_rand();
        lfsr ^= lfsr << 13;
        lfsr ^= lfsr >> 17;
        lfsr ^= lfsr << 5;
        return int'($signed(lfsr[15:0]));
    endfunction

    task automatic send(input bit v, input bit s, input int x);
        @(negedge clk);
        in_valid  = v;
        in_start  = s;
        in_sample = 16'(x);
    endtask

    task automatic frame(input int x[NP], input string tag);
        for (int k = 0; k < NP; k++) begin
            q_bin.push_back(k);
            q_re.push_back(dft_part(x, k, 1'b0));
            q_im.push_back(dft_part(x, k, 1'b1));
            q_tag.push_back(tag);
        end
        for (int n = 0; n < NP; n++) send(1'b1, n == 0, x[n]);
    endtask

    task automatic drain();
        for (int n = 0; n < NP + 1; n++) send(1'b1, 1'b0, 0);
        send(1'b0, 1'b0, 0);
        send(1'b0, 1'b0, 0);
    endtask

    // Idle cycle with junk on the other inputs (R9); output must be low after it (R4).
    task automatic gap();
        send(1'b0, 1'b1, 16'h5a5a);
        @(posedge clk);
        #5;
        chk(out_valid == 1'b0, "R4", "out_valid after idle cycle", int'(out_valid), 0);
    endtask

    // Result monitor: in-order comparison against the expectation queue (R1, R2).
    always @(negedge clk) begin
        if (rst_n && out_valid) begin
            outs++;
            if (first_out < 0) first_out = cyc;
            last_out = cyc;
            if (q_bin.size() == 0) begin
                chk(1'b0, "R6", "unexpected result bin", int'(out_bin), -1);
            end else begin
                int eb, er, ei;
                string tg;
                eb = q_bin.pop_front();
                er = q_re.pop_front();
                ei = q_im.pop_front();
                tg = q_tag.pop_front();
                chk(int'(out_bin) == eb, "R2", "bin order", int'(out_bin), eb);
                chk((int'(out_re) - er <= 2) && (er - int'(out_re) <= 2), tg, "real part", int'(out_re), er);
                chk((int'(out_im) - ei <= 2) && (ei - int'(out_im) <= 2), tg, "imag part", int'(out_im), ei);
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        int fr[NP];
        int base;

        // R7: reset state
        repeat (3) @(negedge clk);
        chk(out_valid == 1'b0, "R7", "out_valid in reset", int'(out_valid), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(out_valid == 1'b0, "R7", "out_valid after reset", int'(out_valid), 0);

        // R7: frame cut by reset yields nothing
        base = outs;
        send(1'b1, 1'b1, 1000);
        send(1'b1, 1'b0, 2000);
        @(negedge clk);
        rst_n = 1'b0;
        in_valid = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        for (int n = 0; n < 2 * NP; n++) send(1'b1, 1'b0, 777);
        send(1'b0, 1'b0, 0);
        send(1'b0, 1'b0, 0);
        chk(outs == base, "R7", "results after mid-frame reset", outs - base, 0);

        // R3: bin k due k steps after the last sample
        for (int n = 0; n < NP; n++) fr[n] = 3000 * (n + 1);
        frame(fr, "R3");
        for (int j = 0; j < NP; j++) begin
            @(negedge clk);
            chk(out_valid && int'(out_bin) == j, "R3", "bin slot", out_valid ? int'(out_bin) : -1, j);
            in_valid = 1'b1;
            in_start = 1'b0;
            in_sample = '0;
        end
        drain();

        // R1: impulse sweep over every position and extreme values
        for (int p = 0; p < NP; p++) begin
            for (int vi = 0; vi < 4; vi++) begin
                for (int n = 0; n < NP; n++) fr[n] = 0;
                fr[p] = (vi == 0) ? 32767 : (vi == 1) ? -32768 : (vi == 2) ? 1 : -1;
                frame(fr, "R1");
            end
        end
        for (int n = 0; n < NP; n++) fr[n] = 32767;
        frame(fr, "R1");
        for (int n = 0; n < NP; n++) fr[n] = -32768;
        frame(fr, "R1");
        for (int n = 0; n < NP; n++) fr[n] = (n % 2 == 0) ? 32767 : -32768;
        frame(fr, "R1");
        for (int n = 0; n < NP; n++) fr[n] = -20000 + 15000 * n;
        frame(fr, "R1");
        drain();

        // R2: back-to-back burst, one result per step
        base = outs;
        first_out = -1;
        for (int f = 0; f < BURST; f++) begin
            for (int n = 0; n < NP; n++) fr[n] = next_rand();
            frame(fr, "R1");
        end
        drain();
        chk(outs - base == BURST * NP, "R2", "burst result count", outs - base, BURST * NP);
        chk(last_out - first_out + 1 == BURST * NP, "R2", "burst span cycles",
            last_out - first_out + 1, BURST * NP);

        // R4 / R9: idle cycles inside a frame and during drain
        for (int n = 0; n < NP; n++) fr[n] = 11111 - 9000 * n;
        for (int k = 0; k < NP; k++) begin
            q_bin.push_back(k);
            q_re.push_back(dft_part(fr, k, 1'b0));
            q_im.push_back(dft_part(fr, k, 1'b1));
            q_tag.push_back("R4");
        end
        for (int n = 0; n < NP; n++) begin
            send(1'b1, n == 0, fr[n]);
            gap();
            gap();
        end
        for (int n = 0; n < NP; n++) begin
            send(1'b1, 1'b0, 0);
            gap();
        end
        drain();

        // R5: restart abandons a partial frame
        base = outs;
        send(1'b1, 1'b1, 5000);
        send(1'b1, 1'b0, -7000);
        for (int n = 0; n < NP; n++) fr[n] = 1234 * (n + 2);
        frame(fr, "R5");
        drain();
        chk(outs - base == NP, "R5", "results after restart", outs - base, NP);

        // R6: samples without a start marker while idle
        base = outs;
        for (int n = 0; n < 5; n++) send(1'b1, 1'b0, 9999 - n);
        drain();
        chk(outs == base, "R6", "results from unmarked samples", outs - base, 0);

        chk(q_bin.size() == 0, "R2", "results still outstanding", q_bin.size(), 0);
        done = 1'b1;
        summary();
        $finish;
    end
endmodule